// File: doc/BRIEF.md
# Pulsed Address Gate with Per-Period Word Cap

This block sits on the read-address and write-address channels between a bus master and the memory system behind it. It models competing traffic. A free-running phase timer splits time into an open stretch and a closed stretch, and the pair repeats without end. The open stretch lasts `cfg_on_len` cycles and the closed stretch lasts `cfg_off_len` cycles. Addresses reach the downstream side only while the timer is open.

On top of that duty pattern, a budget limits how many 64-bit words may be requested in each period. A burst carrying a length field `len` asks for `len+1` words. The burst is let through only if the words already granted in this period, plus its own words, stay within `cfg_cap`. A cap of zero switches the budget off. The word tally goes back to zero whenever a new period begins.

Only the valid/ready pair of each address channel is touched. Address payloads, data channels and responses pass around the block. A request that has already been shown downstream is never pulled back.

Top module: `pulse_addr_gate`

## Requirements
- R1: After reset release the gate is open for `cfg_on_len` cycles, then closed for `cfg_off_len` cycles, and this repeats. Cycle k after release (k = 0 is the first) is open exactly when (k mod (on+off)) < on.
- R2: When `cfg_off_len` is 0 the gate is open in every cycle. The period is then `cfg_on_len` cycles, or 1 cycle when that is also 0.
- R3: When `cfg_on_len` is 0 and `cfg_off_len` is nonzero, no new address is ever passed downstream.
- R4: In a cycle where a channel's gate is open, its downstream valid equals its upstream valid and its upstream ready equals its downstream ready. Where the gate is shut, both are 0.
- R5: A `cfg_cap` of 0 places no limit on words per period.
- R6: With a nonzero cap, a burst of `len+1` words (len in bits [LEN_W-1:0] of the length port) passes only if words_granted + len + 1 <= `cfg_cap`. Words are charged at the downstream handshake on either channel.
- R7: The words-granted tally is 0 in the first cycle of every period. A period starts at cycle k > 0 where k mod P = 0, with P as in R1, or as in R2 when the closed length is 0.
- R8: The read and write channels share one budget, and the read channel has priority. When the read request is presented and its gate is open, the write fit test also counts the read burst's words.
- R9: Once a downstream valid is high without ready, it stays high until the handshake happens, whatever the phase or the budget does.
- R10: After reset the timer starts in the open phase with a tally of 0. A burst that fits in the cap passes in cycle 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_on_len | input | PH_W | Open-phase length in cycles |
| cfg_off_len | input | PH_W | Closed-phase length in cycles |
| cfg_cap | input | CAP_W | Words allowed per period, 0 = unlimited |
| s_arvalid | input | 1 | Read request valid from master |
| s_arready | output | 1 | Read request ready to master |
| s_arlen | input | LEN_W | Read burst length minus one |
| m_arvalid | output | 1 | Read request valid downstream |
| m_arready | input | 1 | Read request ready from downstream |
| s_awvalid | input | 1 | Write request valid from master |
| s_awready | output | 1 | Write request ready to master |
| s_awlen | input | LEN_W | Write burst length minus one |
| m_awvalid | output | 1 | Write request valid downstream |
| m_awready | input | 1 | Write request ready from downstream |

## Verification
The bench sweeps every combination of zero, small and larger settings for the open length, closed length and cap. It runs random requests of short bursts and compares each cycle against an arithmetic model of the phase and the tally. Zero lengths are the sharpest edges. A timer that counts one cycle too many, or that treats a zero open length as a one-cycle window, shifts every later boundary or lets traffic leak through a gate that should stay shut. A tally that is not cleared at the period edge, or that counts the edge's own handshake, starves the next period. A write check that ignores the read request in the same cycle overshoots the cap. A design that drops a pending downstream valid when the phase closes is caught by holding downstream ready low across the boundary.

// File: rtl/pag_pkg.sv
package pag_pkg;
  typedef enum logic {PH_OFF = 1'b0, PH_ON = 1'b1} phase_e;
endpackage

// File: rtl/pag_phase_timer.sv
module pag_phase_timer
  import pag_pkg::*;
#(
  parameter int PH_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] on_len,
  input  logic [PH_W-1:0] off_len,
  output logic            open,
  output logic            new_period
);
  phase_e          ph_q;
  logic [PH_W-1:0] tick_q;
  logic            end_on;
  logic            end_off;

  assign end_on  = (on_len == '0) || (tick_q == on_len - PH_W'(1));
  assign end_off = (off_len == '0) || (tick_q == off_len - PH_W'(1));

  // a period restarts either when a closed stretch ends, or when an open
  // stretch ends with no closed stretch configured
  assign new_period = (ph_q == PH_ON) ? (end_on && off_len == '0) : end_off;
  assign open       = (ph_q == PH_ON) && (on_len != '0 || off_len == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_ON;
      tick_q <= '0;
    end else if (ph_q == PH_ON) begin
      if (end_on) begin
        tick_q <= '0;
        if (off_len != '0) ph_q <= PH_OFF;
      end else begin
        tick_q <= tick_q + PH_W'(1);
      end
    end else begin
      if (end_off) begin
        tick_q <= '0;
        ph_q   <= PH_ON;
      end else begin
        tick_q <= tick_q + PH_W'(1);
      end
    end
  end
endmodule

// File: rtl/pag_budget.sv
module pag_budget #(
  parameter int CAP_W = 16,
  parameter int LEN_W = 8,
  localparam int WRD_W = CAP_W + 1,
  localparam int SUM_W = CAP_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CAP_W-1:0] cap,
  input  logic             new_period,
  input  logic [LEN_W-1:0] ar_len,
  input  logic [LEN_W-1:0] aw_len,
  input  logic             ar_resv,
  input  logic             ar_hs,
  input  logic             aw_hs,
  output logic             fit_ar,
  output logic             fit_aw,
  output logic [WRD_W-1:0] used
);
  localparam logic [SUM_W-1:0] WRD_MAX = SUM_W'({WRD_W{1'b1}});

  logic [WRD_W-1:0] used_q;
  logic [SUM_W-1:0] ar_words, aw_words, need_ar, need_aw, cap_x, nxt;

  assign ar_words = SUM_W'(ar_len) + SUM_W'(1);
  assign aw_words = SUM_W'(aw_len) + SUM_W'(1);
  assign cap_x    = SUM_W'(cap);
  assign need_ar  = SUM_W'(used_q) + ar_words;
  assign need_aw  = SUM_W'(used_q) + (ar_resv ? ar_words : '0) + aw_words;
  assign fit_ar   = (cap == '0) || (need_ar <= cap_x);
  assign fit_aw   = (cap == '0) || (need_aw <= cap_x);
  assign nxt      = SUM_W'(used_q) + (ar_hs ? ar_words : '0) + (aw_hs ? aw_words : '0);
  assign used     = used_q;

  always_ff @(posedge clk) begin
    if (rst || new_period) used_q <= '0;
    else if (nxt > WRD_MAX) used_q <= WRD_MAX[WRD_W-1:0];
    else                    used_q <= nxt[WRD_W-1:0];
  end
endmodule

// File: rtl/pag_chan_gate.sv
module pag_chan_gate (
  input  logic clk,
  input  logic rst,
  input  logic allow,
  input  logic s_valid,
  output logic s_ready,
  output logic m_valid,
  input  logic m_ready,
  output logic gate,
  output logic held,
  output logic hs
);
  logic held_q;

  assign gate    = held_q | allow;
  assign m_valid = s_valid & gate;
  assign s_ready = m_ready & gate;
  assign hs      = m_valid & m_ready;
  assign held    = held_q;

  always_ff @(posedge clk) begin
    if (rst) held_q <= 1'b0;
    else     held_q <= m_valid & ~m_ready;
  end
endmodule

// File: rtl/pulse_addr_gate.sv
module pulse_addr_gate #(
  parameter int PH_W  = 16,
  parameter int CAP_W = 16,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PH_W-1:0]  cfg_on_len,
  input  logic [PH_W-1:0]  cfg_off_len,
  input  logic [CAP_W-1:0] cfg_cap,
  input  logic             s_arvalid,
  output logic             s_arready,
  input  logic [LEN_W-1:0] s_arlen,
  output logic             m_arvalid,
  input  logic             m_arready,
  input  logic             s_awvalid,
  output logic             s_awready,
  input  logic [LEN_W-1:0] s_awlen,
  output logic             m_awvalid,
  input  logic             m_awready
);
  localparam int WRD_W = CAP_W + 1;

  logic             ph_open, new_period;
  logic             fit_ar, fit_aw;
  logic             gate_ar, gate_aw;
  logic             held_ar, held_aw;
  logic             hs_ar, hs_aw;
  logic             ar_resv;
  logic [WRD_W-1:0] words_used;

  pag_phase_timer #(.PH_W(PH_W)) u_timer (
    .clk(clk), .rst(rst), .on_len(cfg_on_len), .off_len(cfg_off_len),
    .open(ph_open), .new_period(new_period)
  );

  assign ar_resv = s_arvalid & gate_ar;

  pag_budget #(.CAP_W(CAP_W), .LEN_W(LEN_W)) u_budget (
    .clk(clk), .rst(rst), .cap(cfg_cap), .new_period(new_period),
    .ar_len(s_arlen), .aw_len(s_awlen), .ar_resv(ar_resv),
    .ar_hs(hs_ar), .aw_hs(hs_aw),
    .fit_ar(fit_ar), .fit_aw(fit_aw), .used(words_used)
  );

  pag_chan_gate u_ar (
    .clk(clk), .rst(rst), .allow(ph_open & fit_ar),
    .s_valid(s_arvalid), .s_ready(s_arready),
    .m_valid(m_arvalid), .m_ready(m_arready),
    .gate(gate_ar), .held(held_ar), .hs(hs_ar)
  );

  pag_chan_gate u_aw (
    .clk(clk), .rst(rst), .allow(ph_open & fit_aw),
    .s_valid(s_awvalid), .s_ready(s_awready),
    .m_valid(m_awvalid), .m_ready(m_awready),
    .gate(gate_aw), .held(held_aw), .hs(hs_aw)
  );
endmodule

// File: rtl/pag_checker.sv
module pag_checker #(
  parameter int PH_W  = 16,
  parameter int CAP_W = 16,
  parameter int LEN_W = 8,
  localparam int WRD_W = CAP_W + 1
) (
  input logic             clk,
  input logic             rst,
  input logic [PH_W-1:0]  cfg_on_len,
  input logic [PH_W-1:0]  cfg_off_len,
  input logic [CAP_W-1:0] cfg_cap,
  input logic             s_arvalid,
  input logic             s_arready,
  input logic [LEN_W-1:0] s_arlen,
  input logic             m_arvalid,
  input logic             m_arready,
  input logic             s_awvalid,
  input logic             s_awready,
  input logic             m_awvalid,
  input logic             m_awready,
  input logic             held_ar,
  input logic             held_aw,
  input logic [WRD_W-1:0] words_used
);
  a_r9_ar_hold: assert property (@(posedge clk) disable iff (rst)
    (m_arvalid && !m_arready) |=> m_arvalid);
  a_r9_aw_hold: assert property (@(posedge clk) disable iff (rst)
    (m_awvalid && !m_awready) |=> m_awvalid);
  a_r4_ar_handshake: assert property (@(posedge clk) disable iff (rst)
    (m_arvalid && m_arready) == (s_arvalid && s_arready));
  a_r4_aw_handshake: assert property (@(posedge clk) disable iff (rst)
    (m_awvalid && m_awready) == (s_awvalid && s_awready));
  a_r3_ar_closed: assert property (@(posedge clk) disable iff (rst)
    (cfg_on_len == '0 && cfg_off_len != '0 && !held_ar) |-> !m_arvalid);
  a_r3_aw_closed: assert property (@(posedge clk) disable iff (rst)
    (cfg_on_len == '0 && cfg_off_len != '0 && !held_aw) |-> !m_awvalid);
  a_r2_always_open: assert property (@(posedge clk) disable iff (rst)
    (cfg_off_len == '0 && cfg_cap == '0 && s_arvalid) |-> m_arvalid);
  a_r6_ar_cap: assert property (@(posedge clk) disable iff (rst)
    (cfg_cap != '0 && m_arvalid && m_arready && !held_ar) |->
      (32'(words_used) + 32'(s_arlen) + 32'd1 <= 32'(cfg_cap)));
endmodule

bind pulse_addr_gate pag_checker #(.PH_W(PH_W), .CAP_W(CAP_W), .LEN_W(LEN_W)) u_pag_chk (
  .clk(clk), .rst(rst), .cfg_on_len(cfg_on_len), .cfg_off_len(cfg_off_len),
  .cfg_cap(cfg_cap), .s_arvalid(s_arvalid), .s_arready(s_arready),
  .s_arlen(s_arlen), .m_arvalid(m_arvalid), .m_arready(m_arready),
  .s_awvalid(s_awvalid), .s_awready(s_awready), .m_awvalid(m_awvalid),
  .m_awready(m_awready), .held_ar(held_ar), .held_aw(held_aw),
  .words_used(words_used)
);

// File: tb/pulse_addr_gate_bench.sv
module pulse_addr_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PH_W = 16, CAP_W = 16, LEN_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PH_W-1:0]  cfg_on_len = '0, cfg_off_len = '0;
  logic [CAP_W-1:0] cfg_cap = '0;
  logic s_arvalid = 0, m_arready = 0, s_awvalid = 0, m_awready = 0;
  logic [LEN_W-1:0] s_arlen = '0, s_awlen = '0;
  logic s_arready, m_arvalid, s_awready, m_awvalid;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pulse_addr_gate #(.PH_W(PH_W), .CAP_W(CAP_W), .LEN_W(LEN_W)) u_pulse_addr_gate (
    .clk(clk), .rst(rst), .cfg_on_len(cfg_on_len), .cfg_off_len(cfg_off_len),
    .cfg_cap(cfg_cap), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_arlen(s_arlen), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .s_awvalid(s_awvalid), .s_awready(s_awready), .s_awlen(s_awlen),
    .m_awvalid(m_awvalid), .m_awready(m_awready)
  );

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // reset with a new configuration; returns at the negedge of cycle k = 0
  task automatic do_reset(input int on, input int off, input int cap);
    @(negedge clk);
    rst = 1'b1;
    cfg_on_len = PH_W'(on); cfg_off_len = PH_W'(off); cfg_cap = CAP_W'(cap);
    s_arvalid = 0; s_awvalid = 0; m_arready = 0; m_awready = 0;
    s_arlen = '0; s_awlen = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  function automatic int period_of(input int on, input int off);
    if (off == 0) return (on == 0) ? 1 : on;
    return on + off;
  endfunction

  function automatic bit phase_open(input int on, input int off, input int k);
    if (off == 0) return 1'b1;
    if (on == 0) return 1'b0;
    return (k % (on + off)) < on;
  endfunction

  function automatic string phase_tag(input int on, input int off);
    if (on == 0 && off != 0) return "R3";
    if (off == 0) return "R2";
    return "R1";
  endfunction

  task automatic run_cfg(input int on, input int off, input int cap, input int ncyc);
    int used;
    int P;
    do_reset(on, off, cap);
    P = period_of(on, off);
    used = 0;
    m_arready = 1; m_awready = 1;
    for (int k = 0; k < ncyc; k++) begin
      bit po, arf, awf, aro, awo, awalone;
      int arw, aww, res;
      string tar, taw;
      s_arvalid = $urandom_range(0, 1);
      s_awvalid = $urandom_range(0, 1);
      s_arlen   = LEN_W'($urandom_range(0, 3));
      s_awlen   = LEN_W'($urandom_range(0, 3));
      #1;
      if (k > 0 && (k % P) == 0) used = 0;
      po  = phase_open(on, off, k);
      arw = int'(s_arlen) + 1;
      aww = int'(s_awlen) + 1;
      arf = (cap == 0) || (used + arw <= cap);
      aro = po && arf;
      res = (s_arvalid && aro) ? arw : 0;
      awf = (cap == 0) || (used + res + aww <= cap);
      awalone = (cap == 0) || (used + aww <= cap);
      awo = po && awf;
      if (!po) tar = phase_tag(on, off);
      else if (!arf) tar = "R6";
      else if (k > 0 && (k % P) == 0 && cap != 0) tar = "R7";
      else if (cap == 0) tar = "R5";
      else tar = "R4";
      if (!po) taw = phase_tag(on, off);
      else if (!awf) taw = awalone ? "R8" : "R6";
      else if (k > 0 && (k % P) == 0 && cap != 0) taw = "R7";
      else if (cap == 0) taw = "R5";
      else taw = "R4";
      chk(s_arready, aro, tar, "s_arready");
      chk(m_arvalid, s_arvalid && aro, tar, "m_arvalid");
      chk(s_awready, awo, taw, "s_awready");
      chk(m_awvalid, s_awvalid && awo, taw, "m_awvalid");
      if (s_arvalid && aro) used += arw;
      if (s_awvalid && awo) used += aww;
      @(negedge clk);
    end
    s_arvalid = 0; s_awvalid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_errors++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    // R10: reset state, checked while reset is held and in cycle 0
    do_reset(4, 2, 4);
    s_arvalid = 1; s_arlen = 8'd3; m_arready = 1;
    #1;
    chk(s_arready, 1'b1, "R10", "first-cycle full-cap burst ready");
    chk(m_arvalid, 1'b1, "R10", "first-cycle full-cap burst valid");
    @(negedge clk);
    s_arlen = 8'd0;
    #1;
    chk(s_arready, 1'b0, "R6", "cap exhausted, 1-word burst blocked");
    repeat (5) @(negedge clk);
    #1;
    chk(s_arready, 1'b1, "R7", "tally cleared at period start (k=6)");

    // R8: shared budget, read has priority
    do_reset(4, 2, 4);
    m_arready = 1; m_awready = 1;
    s_arvalid = 1; s_arlen = 8'd1; s_awvalid = 1; s_awlen = 8'd2;
    #1;
    chk(s_arready, 1'b1, "R8", "read passes with write offered");
    chk(s_awready, 1'b0, "R8", "write blocked by read reservation");
    @(negedge clk);
    s_arvalid = 0;
    #1;
    chk(s_awready, 1'b0, "R6", "write over remaining budget");
    s_awlen = 8'd1;
    #1;
    chk(s_awready, 1'b1, "R6", "write equal to remaining budget");
    s_awvalid = 0;

    // R9: pending request held across the closed phase
    do_reset(3, 5, 0);
    s_arvalid = 1; m_arready = 0;
    for (int k = 0; k < 6; k++) begin
      #1;
      chk(m_arvalid, 1'b1, "R9", $sformatf("held valid k=%0d", k));
      chk(s_arready, 1'b0, "R9", $sformatf("no ready while blocked k=%0d", k));
      @(negedge clk);
    end
    m_arready = 1;
    #1;
    chk(s_arready, 1'b1, "R9", "held request completes in closed phase");
    @(negedge clk);
    #1;
    chk(m_arvalid, 1'b0, "R1", "new request blocked in closed phase k=7");
    @(negedge clk);
    #1;
    chk(m_arvalid, 1'b1, "R1", "reopen at k=8");
    s_arvalid = 0;

    // sweep of small configurations
    foreach (ON_SET[i]) ;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++) begin
          int on_v, off_v, cap_v;
          on_v  = (a == 0) ? 0 : (a == 1) ? 1 : 3;
          off_v = (b == 0) ? 0 : (b == 1) ? 2 : 5;
          cap_v = (c == 0) ? 0 : (c == 1) ? 3 : 7;
          run_cfg(on_v, off_v, cap_v, 48);
        end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  int ON_SET[1] = '{0};
endmodule